// File: doc/BRIEF.md
# Generation-Tagged Decode Steering Stage

This stage sits between instruction fetch and the two back-end paths of a small in-order pipeline. Fetch delivers whole cache lines, each tagged with the address it was fetched for and the generation it was fetched in. The stage keeps the architectural decode address and picks the word at that address out of the current line. It classifies the word and sends it either to the queue that resolves indirect addresses or straight to execute. Each instruction carries the generation, its address and a sequence number.

Nothing is flushed by wires. The stage owns an 8-bit generation count. A line from any other generation is dropped quietly. If the line does not cover the decode address, the stage drops it, asks for a refetch at the decode address and bumps the generation. A restart from execute reloads the whole architectural view in one cycle. The stage also counts stores that it has sent on speculatively. An instruction that needs a load waits until that count equals the completed-store count presented by the back end.

The decoder is a stand-in that reads four flag bits and a jump target from each word. Outputs are combinational: valid and ready are produced in the same cycle as the inputs that caused them.

Top module: `decode_steer`

## Requirements
- R1: The stage consumes a line (`bnd_ready`=1) or emits an instruction only in a cycle where `bnd_valid`, `ind_ready` and `exe_ready` are all 1.
- R2: A line whose `bnd_gen` differs from the effective generation is popped, produces no instruction and no refetch request, and leaves decode address, sequence and store count unchanged.
- R3: A current-generation line whose address bits above the low `LINE_W` bits differ from those of the decode address is popped. In the same cycle `rq_valid`=1 and `rq_pc` equals the decode address, and `gen_o` is one higher in the following cycle (mod 256). No request is made and no increment happens when `rs_valid` is 1 in that cycle.
- R4: An instruction whose word has bit 11 (indirect) or bit 10 (execute load) set is not issued and the line is not popped while the speculative store count differs from `st_done`.
- R5: On issue, `ins_word` is the word at slot `pc[LINE_W-1:0]` of the line. `ins_pc`, `ins_gen` and `ins_seq` are the decode address, generation and sequence count. The sequence count then increases by one. The decode address becomes `{pc[PC_W-1:7], word[6:0]}` when bit 8 (jump) is set, and pc+1 (mod 2^PC_W) otherwise.
- R6: On issue, the speculative store count increases by one if bits 11 and 7 (autoincrement) are both set, plus one if bit 9 (execute store) is set.
- R7: An issued word with bit 11 set appears on the indirect port (`ind_valid`), and any other word appears on the execute port (`exe_valid`). Both are never high together.
- R8: After an issue, the line is popped only if the new decode address lies in a different line. Otherwise it is held for the next word.
- R9: With `rs_valid`=1, decode address, generation, sequence and store count take the `rs_*` values, and the interrupt flag is OR-ed with `rs_irq`. These values already govern that cycle's decision.
- R10: `ins_irq` carries the pending interrupt flag, and the flag clears on every issue.
- R11: After reset, the generation is 0, the decode address is `RESET_PC`, and sequence, store count and interrupt flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bnd_valid | input | 1 | fetch line present |
| bnd_ready | output | 1 | fetch line popped this cycle |
| bnd_pc | input | PC_W | address the line was fetched for |
| bnd_gen | input | GEN_W | generation of the line |
| bnd_data | input | WORD_W<<LINE_W | line words, slot k at bits k*WORD_W |
| ind_valid | output | 1 | instruction to indirect queue |
| ind_ready | input | 1 | indirect queue can accept |
| exe_valid | output | 1 | instruction to execute queue |
| exe_ready | input | 1 | execute queue can accept |
| ins_word | output | WORD_W | issued instruction word |
| ins_pc | output | PC_W | issued instruction address |
| ins_gen | output | GEN_W | issued instruction generation |
| ins_seq | output | SEQ_W | issued instruction sequence number |
| ins_irq | output | 1 | interrupt pending at issue |
| rs_valid | input | 1 | restart from execute |
| rs_pc | input | PC_W | restart decode address |
| rs_gen | input | GEN_W | restart generation |
| rs_seq | input | SEQ_W | restart sequence number |
| rs_stores | input | CNT_W | restart speculative store count |
| rs_irq | input | 1 | restart interrupt request |
| st_done | input | CNT_W | completed store count |
| rq_valid | output | 1 | refetch request |
| rq_pc | output | PC_W | refetch address |
| gen_o | output | GEN_W | current generation |

## Verification
Every handshake, payload and refetch output is due in the same cycle as the inputs that caused it. The bench drives inputs on the falling edge and compares all outputs with its model one time unit later, before the next rising edge. Register effects are due at the next rising edge: the new generation, decode address, sequence and store count. The model advances its own state at that same edge, so they show up in the following cycle's comparison: `gen_o`, the payload tags, and stall versus issue. Random stimulus mixes stale and mismatched lines, store-count gaps, restarts and back-pressure over several thousand cycles.

// File: rtl/decode_steer_pkg.sv
package decode_steer_pkg;
    localparam int BIT_IND  = 11;
    localparam int BIT_XLD  = 10;
    localparam int BIT_XST  = 9;
    localparam int BIT_JMP  = 8;
    localparam int BIT_AINC = 7;
    localparam int TGT_W    = 7;

    typedef struct packed {
        logic need_ind;
        logic need_xld;
        logic [1:0] st_inc;
        logic       jump;
    } cls_t;
endpackage

// File: rtl/line_pick.sv
module line_pick #(
    parameter int WORD_W = 12,
    parameter int LINE_W = 2
) (
    input  logic [(WORD_W<<LINE_W)-1:0] line_i,
    input  logic [LINE_W-1:0]           slot_i,
    output logic [WORD_W-1:0]           word_o
);
    localparam int NWORDS = 1 << LINE_W;

    logic [WORD_W-1:0] words [NWORDS];

    for (genvar k = 0; k < NWORDS; k++) begin : g_slot
        assign words[k] = line_i[k*WORD_W +: WORD_W];
    end

    assign word_o = words[slot_i];
endmodule

// File: rtl/insn_classify.sv
module insn_classify
    import decode_steer_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int PC_W   = 12
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [PC_W-1:0]   pc_i,
    output cls_t              cls_o,
    output logic [PC_W-1:0]   next_pc_o
);
    always_comb begin
        cls_o.need_ind = word_i[BIT_IND];
        cls_o.need_xld = word_i[BIT_XLD];
        cls_o.jump     = word_i[BIT_JMP];
        cls_o.st_inc   = {1'b0, word_i[BIT_IND] & word_i[BIT_AINC]}
                       + {1'b0, word_i[BIT_XST]};
        if (word_i[BIT_JMP])
            next_pc_o = {pc_i[PC_W-1:TGT_W], word_i[TGT_W-1:0]};
        else
            next_pc_o = pc_i + PC_W'(1);
    end
endmodule

// File: rtl/decode_steer.sv
module decode_steer
    import decode_steer_pkg::*;
#(
    parameter int PC_W     = 12,
    parameter int WORD_W   = 12,
    parameter int LINE_W   = 2,
    parameter int GEN_W    = 8,
    parameter int SEQ_W    = 16,
    parameter int CNT_W    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bnd_valid,
    output logic                         bnd_ready,
    input  logic [PC_W-1:0]              bnd_pc,
    input  logic [GEN_W-1:0]             bnd_gen,
    input  logic [(WORD_W<<LINE_W)-1:0]  bnd_data,
    output logic                         ind_valid,
    input  logic                         ind_ready,
    output logic                         exe_valid,
    input  logic                         exe_ready,
    output logic [WORD_W-1:0]            ins_word,
    output logic [PC_W-1:0]              ins_pc,
    output logic [GEN_W-1:0]             ins_gen,
    output logic [SEQ_W-1:0]             ins_seq,
    output logic                         ins_irq,
    input  logic                         rs_valid,
    input  logic [PC_W-1:0]              rs_pc,
    input  logic [GEN_W-1:0]             rs_gen,
    input  logic [SEQ_W-1:0]             rs_seq,
    input  logic [CNT_W-1:0]             rs_stores,
    input  logic                         rs_irq,
    input  logic [CNT_W-1:0]             st_done,
    output logic                         rq_valid,
    output logic [PC_W-1:0]              rq_pc,
    output logic [GEN_W-1:0]             gen_o
);
    localparam int TAG_W = PC_W - LINE_W;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [GEN_W-1:0] gen;
        logic [SEQ_W-1:0] seq;
        logic [CNT_W-1:0] spec;
        logic             irq;
    } st_t;

    st_t st_q, st_d, eff;

    logic [WORD_W-1:0] word;
    cls_t              cls;
    logic [PC_W-1:0]   next_pc;
    logic              go, stale, miss, stall, issue;

    // effective view: a restart governs the same cycle
    always_comb begin
        eff = st_q;
        if (rs_valid) begin
            eff.pc   = rs_pc;
            eff.gen  = rs_gen;
            eff.seq  = rs_seq;
            eff.spec = rs_stores;
            eff.irq  = st_q.irq | rs_irq;
        end
    end

    line_pick #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_pick (
        .line_i (bnd_data),
        .slot_i (eff.pc[LINE_W-1:0]),
        .word_o (word)
    );

    insn_classify #(.WORD_W(WORD_W), .PC_W(PC_W)) u_cls (
        .word_i    (word),
        .pc_i      (eff.pc),
        .cls_o     (cls),
        .next_pc_o (next_pc)
    );

    always_comb begin
        st_d      = eff;
        go        = bnd_valid && ind_ready && exe_ready;
        stale     = go && (bnd_gen != eff.gen);
        miss      = go && !stale
                  && (bnd_pc[PC_W-1:LINE_W] != eff.pc[PC_W-1:LINE_W]);
        stall     = go && !stale && !miss
                  && (cls.need_ind || cls.need_xld) && (eff.spec != st_done);
        issue     = go && !stale && !miss && !stall;

        bnd_ready = 1'b0;
        rq_valid  = 1'b0;
        rq_pc     = eff.pc;
        ind_valid = issue && cls.need_ind;
        exe_valid = issue && !cls.need_ind;
        ins_word  = word;
        ins_pc    = eff.pc;
        ins_gen   = eff.gen;
        ins_seq   = eff.seq;
        ins_irq   = eff.irq;

        if (stale) begin
            bnd_ready = 1'b1;
        end
        if (miss) begin
            bnd_ready = 1'b1;
            if (!rs_valid) begin
                rq_valid = 1'b1;
                st_d.gen = eff.gen + GEN_W'(1);
            end
        end
        if (issue) begin
            st_d.seq  = eff.seq + SEQ_W'(1);
            st_d.pc   = next_pc;
            st_d.spec = eff.spec + CNT_W'(cls.st_inc);
            st_d.irq  = 1'b0;
            bnd_ready = (next_pc[PC_W-1:LINE_W] != TAG_W'(bnd_pc[PC_W-1:LINE_W]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc   <= RESET_PC;
            st_q.gen  <= '0;
            st_q.seq  <= '0;
            st_q.spec <= '0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_o = st_q.gen;

    AST_CONSUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_ready || ind_valid || exe_valid) |-> (bnd_valid && ind_ready && exe_ready)); // R1
    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(ind_valid && exe_valid)); // R7
    AST_STALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && !rs_valid && bnd_gen != st_q.gen) |-> !(ind_valid || exe_valid || rq_valid)); // R2
    AST_GEN_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |=> gen_o == $past(gen_o) + GEN_W'(1)); // R3
    AST_NO_REQ_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> !rq_valid); // R3
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_valid || exe_valid) |=> st_q.seq == $past(ins_seq) + SEQ_W'(1)); // R5
    AST_IDLE_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_valid && !ind_valid && !exe_valid) |=> $stable(st_q.pc)); // R5
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_valid || exe_valid) |=> !st_q.irq); // R10
endmodule

// File: tb/decode_steer_test.sv
module decode_steer_test;
    localparam int PC_W = 12, WORD_W = 12, LINE_W = 2, GEN_W = 8, SEQ_W = 16, CNT_W = 8;
    localparam int NW = 1 << LINE_W;

    logic clk = 0, rst_n = 0;
    logic bnd_valid = 0, ind_ready = 0, exe_ready = 0, rs_valid = 0, rs_irq = 0;
    logic [PC_W-1:0] bnd_pc = '0, rs_pc = '0;
    logic [GEN_W-1:0] bnd_gen = '0, rs_gen = '0;
    logic [(WORD_W<<LINE_W)-1:0] bnd_data = '0;
    logic [SEQ_W-1:0] rs_seq = '0;
    logic [CNT_W-1:0] rs_stores = '0, st_done = '0;
    logic bnd_ready, ind_valid, exe_valid, ins_irq, rq_valid;
    logic [WORD_W-1:0] ins_word;
    logic [PC_W-1:0] ins_pc, rq_pc;
    logic [GEN_W-1:0] ins_gen, gen_o;
    logic [SEQ_W-1:0] ins_seq;

    always #5 clk = ~clk;

    decode_steer uut (.*);

    int checks = 0, fails = 0;
    // model state
    int mpc, mgen, mseq, mspec, mirq;
    // expected outputs and next state
    int e_pop, e_ind, e_exe, e_rq, e_rqpc, e_word, e_pc, e_gen, e_seq, e_irq;
    int n_pc, n_gen, n_seq, n_spec, n_irq;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model();
        int epc, egen, eseq, espec, eirq, w;
        epc = rs_valid ? int'(rs_pc) : mpc;
        egen = rs_valid ? int'(rs_gen) : mgen;
        eseq = rs_valid ? int'(rs_seq) : mseq;
        espec = rs_valid ? int'(rs_stores) : mspec;
        eirq = rs_valid ? (mirq | int'(rs_irq)) : mirq;
        n_pc = epc; n_gen = egen; n_seq = eseq; n_spec = espec; n_irq = eirq;
        e_pop = 0; e_ind = 0; e_exe = 0; e_rq = 0; e_rqpc = epc;
        e_pc = epc; e_gen = egen; e_seq = eseq; e_irq = eirq;
        w = int'(bnd_data[(epc % NW)*WORD_W +: WORD_W]);
        e_word = w;
        if (bnd_valid && ind_ready && exe_ready) begin
            if (int'(bnd_gen) != egen) e_pop = 1;
            else if ((int'(bnd_pc) / NW) != (epc / NW)) begin
                e_pop = 1;
                if (!rs_valid) begin e_rq = 1; n_gen = (egen + 1) % 256; end
            end else if ((w[11] || w[10]) && espec != int'(st_done)) begin
                // stall
            end else begin
                if (w[11]) e_ind = 1; else e_exe = 1;
                n_seq = (eseq + 1) % 65536;
                n_pc = w[8] ? ((epc & 'hF80) | (w & 'h7F)) : ((epc + 1) % 4096);
                n_spec = (espec + ((w[11] && w[7]) ? 1 : 0) + (w[9] ? 1 : 0)) % 256;
                n_irq = 0;
                e_pop = ((n_pc / NW) != (epc / NW)) ? 1 : 0;
            end
        end
    endtask

    task automatic compare();
        chk("R1/R2/R3/R8 bnd_ready", int'(bnd_ready), e_pop);
        chk("R4/R6/R7 ind_valid", int'(ind_valid), e_ind);
        chk("R4/R6/R7 exe_valid", int'(exe_valid), e_exe);
        chk("R3 rq_valid", int'(rq_valid), e_rq);
        chk("R3/R9 gen_o", int'(gen_o), mgen);
        if (e_rq) chk("R3 rq_pc", int'(rq_pc), e_rqpc);
        if (e_ind || e_exe) begin
            chk("R5 ins_word", int'(ins_word), e_word);
            chk("R5/R9 ins_pc", int'(ins_pc), e_pc);
            chk("R5/R9 ins_gen", int'(ins_gen), e_gen);
            chk("R5/R9 ins_seq", int'(ins_seq), e_seq);
            chk("R10 ins_irq", int'(ins_irq), e_irq);
        end
    endtask

    function automatic logic [WORD_W-1:0] rand_word();
        logic [WORD_W-1:0] w;
        w = WORD_W'($urandom);
        if ($urandom % 3 != 0) w[8] = 1'b0;
        if ($urandom % 2 == 0) w[11:10] = 2'b00;
        return w;
    endfunction

    task automatic cycle(input int kind);
        int epc, egen;
        @(negedge clk);
        rs_valid = ($urandom % 25 == 0) || kind == 1;
        rs_pc = PC_W'($urandom); rs_gen = GEN_W'($urandom);
        rs_seq = SEQ_W'($urandom); rs_stores = CNT_W'($urandom % 4);
        rs_irq = ($urandom % 2) == 0;
        epc = rs_valid ? int'(rs_pc) : mpc;
        egen = rs_valid ? int'(rs_gen) : mgen;
        bnd_valid = ($urandom % 8) != 0;
        ind_ready = ($urandom % 6) != 0;
        exe_ready = ($urandom % 6) != 0;
        bnd_gen = ($urandom % 10 == 0) ? GEN_W'(egen + 1) : GEN_W'(egen);
        bnd_pc = ($urandom % 8 == 0) ? PC_W'(epc + NW) : PC_W'(epc);
        for (int k = 0; k < NW; k++) bnd_data[k*WORD_W +: WORD_W] = rand_word();
        st_done = ($urandom % 3 == 0) ? CNT_W'(mspec + 1) : CNT_W'(rs_valid ? int'(rs_stores) : mspec);
        #1;
        model();
        compare();
        @(posedge clk);
        mpc = n_pc; mgen = n_gen; mseq = n_seq; mspec = n_spec; mirq = n_irq;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(7));
        mpc = 0; mgen = 0; mseq = 0; mspec = 0; mirq = 0;
        #22;
        chk("R11 gen_o in reset", int'(gen_o), 0);
        chk("R11 no issue in reset", int'(ind_valid | exe_valid | rq_valid), 0);
        rst_n = 1;
        // R11: first issue after reset is at pc 0, seq 0, gen 0
        @(negedge clk);
        bnd_valid = 1; ind_ready = 1; exe_ready = 1; bnd_pc = '0; bnd_gen = '0;
        bnd_data = '0; bnd_data[WORD_W-1:0] = 12'h000; st_done = '0;
        #1;
        chk("R11 reset pc/seq", int'(exe_valid) + int'(ins_pc) + int'(ins_seq) + int'(ins_irq), 1);
        model(); compare();
        @(posedge clk);
        mpc = n_pc; mgen = n_gen; mseq = n_seq; mspec = n_spec; mirq = n_irq;
        cycle(1); // R9 directed restart
        for (int i = 0; i < 4000; i++) cycle(0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule